// File: doc/BRIEF.md
# Shadow Stack Pointer Unit

This block keeps the pointer to the top of a downward-growing shadow stack and carries out three operations on it: a push that stores a link value just below the current top, a pop that reads the word at the top and compares it with the link value, and a read of the pointer. A core hands it one operation at a time. The operation carries a code, the index of the source register and the value of that register, together with an enable flag. The unit then reaches a single-port memory through a request/response handshake. The pointer moves only once the memory access has succeeded and, for a pop, once the compare has passed. This means a failed operation always leaves the stack where it was.

Each operation ends with a one-cycle completion pulse. The pulse carries the pointer value for a read, a software-check exception for a failed compare, an access fault passed through from memory, or a flag for an operation the unit does not handle. The pointer is also a CSR at address 0x011, read combinationally and written on a clock edge. Its lowest bits always read as zero. The unit is parameterised for a 32-bit or 64-bit word.

Top module: `sstk_unit`

## Requirements
- R1: A push (op_code 0) with an accepted source writes op_val to address pointer−XLEN/8 (mem_we high, address and data held until mem_ready), and on an error-free response the pointer becomes that address.
- R2: A push whose response has mem_err set reports op_fault, raises no software-check and leaves the pointer unchanged.
- R3: A pop (op_code 1) reads at the pointer (mem_we low), and when the returned word equals op_val bit for bit the pointer rises by XLEN/8 with no exception.
- R4: A pop whose error-free response differs from op_val raises op_swcheck with op_cause 18 and op_tval 3, and leaves the pointer unchanged.
- R5: A pop with mem_err set reports op_fault only. No software-check is raised even when the data also differs, at most one exception is raised per operation, and the pointer is unchanged.
- R6: Pointer bits 1:0 (and bit 2 when XLEN is 64) always read zero, whatever value is written.
- R7: The pointer resets to zero. It is read and written at CSR address 0x011, while any other CSR address reads zero and its writes do not change the pointer.
- R8: With en low, a read-pointer operation returns zero, and push or pop issue no memory request, complete on the next cycle and leave the pointer unchanged.
- R9: With en high, a read-pointer operation (op_code 2) completes on the next cycle with op_rdata equal to the pointer.
- R10: When en is high, a push or pop whose op_src is neither 1 nor 5 completes on the next cycle with op_unhandled set and no memory request. op_code 3 is always reported as unhandled.
- R11: op_busy is high from the cycle after a memory operation is accepted until its response. New operations presented while busy are ignored, and no memory request is made while idle.
- R12: If a CSR write to the pointer falls in the cycle in which an operation commits its pointer update, the update wins and the CSR write is discarded. When the operation fails instead, the CSR write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| en | input | 1 | Shadow-stack feature enabled |
| op_valid | input | 1 | Operation presented |
| op_code | input | 2 | 0 push, 1 pop, 2 read pointer, 3 unhandled |
| op_src | input | 5 | Source register index |
| op_val | input | XLEN | Source register value |
| op_busy | output | 1 | Memory operation in flight |
| op_done | output | 1 | Completion pulse |
| op_rdata | output | XLEN | Pointer value for read-pointer |
| op_unhandled | output | 1 | Operation not handled |
| op_swcheck | output | 1 | Software-check exception |
| op_cause | output | 5 | Exception cause (18 on software-check) |
| op_tval | output | XLEN | Trap value (3 on software-check) |
| op_fault | output | 1 | Memory access fault |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | XLEN | Request address |
| mem_wdata | output | XLEN | Write data |
| mem_ready | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Response valid |
| mem_rdata | input | XLEN | Read data |
| mem_err | input | 1 | Response carries an access fault |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data |

## Verification
Two pointer writers can act in the same cycle: an operation that commits on its memory response, and a CSR write. The bench provokes this by raising csr_we in the exact cycle that mem_rvalid is driven. It does so in directed cases and in about one random operation in ten, and it covers both successful and failing responses. A model ranks the operation's update above the CSR write only when the operation commits. The pointer read back through the CSR port on the following cycle is compared with that model.

// File: rtl/sstk_unit.sv
module sstk_unit #(
  parameter int          XLEN    = 32,
  parameter logic [11:0] PTR_CSR = 12'h011
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            op_valid,
  input  logic [1:0]      op_code,
  input  logic [4:0]      op_src,
  input  logic [XLEN-1:0] op_val,
  output logic            op_busy,
  output logic            op_done,
  output logic [XLEN-1:0] op_rdata,
  output logic            op_unhandled,
  output logic            op_swcheck,
  output logic [4:0]      op_cause,
  output logic [XLEN-1:0] op_tval,
  output logic            op_fault,
  output logic            mem_req,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic            mem_ready,
  input  logic            mem_rvalid,
  input  logic [XLEN-1:0] mem_rdata,
  input  logic            mem_err,
  input  logic            csr_we,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata
);
  localparam int LOWZ = (XLEN == 64) ? 3 : 2;
  localparam logic [XLEN-1:0] STEP = XLEN'(XLEN / 8);
  localparam logic [XLEN-1:0] KEEP = {{(XLEN-LOWZ){1'b1}}, {LOWZ{1'b0}}};
  localparam logic [1:0] OP_PUSH = 2'd0, OP_POP = 2'd1, OP_RDPTR = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RESP} st_t;

  st_t             st;
  logic [XLEN-1:0] ptr, addr_q, val_q;
  logic            push_q;

  logic accept, mem_op, src_ok, start_mem, resp, match, commit, csr_hit;
  logic [XLEN-1:0] new_ptr;

  assign accept    = op_valid && (st == S_IDLE);
  assign mem_op    = (op_code == OP_PUSH) || (op_code == OP_POP);
  assign src_ok    = (op_src == 5'd1) || (op_src == 5'd5);
  assign start_mem = accept && en && mem_op && src_ok;
  assign resp      = (st == S_RESP) && mem_rvalid;
  assign match     = (mem_rdata == val_q);
  assign commit    = resp && !mem_err && (push_q || match);
  assign new_ptr   = push_q ? addr_q : addr_q + STEP;
  assign csr_hit   = (csr_addr == PTR_CSR);

  assign op_busy   = (st != S_IDLE);
  assign mem_req   = (st == S_REQ);
  assign mem_we    = mem_req && push_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = val_q;
  assign csr_rdata = csr_hit ? ptr : '0;
  assign op_cause  = op_swcheck ? 5'd18 : 5'd0;
  assign op_tval   = op_swcheck ? XLEN'(3) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      val_q  <= '0;
      push_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start_mem) begin
          st     <= S_REQ;
          push_q <= (op_code == OP_PUSH);
          addr_q <= (op_code == OP_PUSH) ? ptr - STEP : ptr;
          val_q  <= op_val;
        end
        S_REQ:   if (mem_ready) st <= S_RESP;
        S_RESP:  if (mem_rvalid) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else if (commit) ptr <= new_ptr & KEEP;
    else if (csr_we && csr_hit) ptr <= csr_wdata & KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_done      <= 1'b0;
      op_rdata     <= '0;
      op_unhandled <= 1'b0;
      op_swcheck   <= 1'b0;
      op_fault     <= 1'b0;
    end else begin
      op_done      <= (accept && !start_mem) || resp;
      op_rdata     <= (accept && en && op_code == OP_RDPTR) ? ptr : '0;
      op_unhandled <= accept && ((op_code == 2'd3) || (en && mem_op && !src_ok));
      op_swcheck   <= resp && !mem_err && !push_q && !match;
      op_fault     <= resp && mem_err;
    end
  end
endmodule

// File: rtl/sstk_unit_chk.sv
module sstk_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_req,
  input logic            mem_ready,
  input logic            mem_we,
  input logic [XLEN-1:0] mem_addr,
  input logic [XLEN-1:0] mem_wdata,
  input logic            op_busy,
  input logic            op_done,
  input logic            op_swcheck,
  input logic            op_fault,
  input logic [4:0]      op_cause,
  input logic [XLEN-1:0] op_tval,
  input logic            csr_we,
  input logic [XLEN-1:0] ptr
);
  localparam int LOWZ = (XLEN == 64) ? 3 : 2;

  assert_req_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  assert_fail_keeps_ptr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op_done && (op_fault || op_swcheck) && !$past(csr_we) |-> ptr == $past(ptr));

  assert_swcheck_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    op_swcheck |-> op_done && op_cause == 5'd18 && op_tval == XLEN'(3));

  assert_single_exception_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_swcheck && op_fault));

  assert_ptr_lowbits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ptr[LOWZ-1:0] == '0);

  assert_no_req_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !op_busy |-> !mem_req);
endmodule

bind sstk_unit sstk_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ready(mem_ready),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .op_busy(op_busy), .op_done(op_done), .op_swcheck(op_swcheck),
  .op_fault(op_fault), .op_cause(op_cause), .op_tval(op_tval),
  .csr_we(csr_we), .ptr(ptr)
);

// File: tb/tb_sstk_unit.sv
module tb_sstk_unit;
  logic        clk = 0, rst_n = 0, en = 1, op_valid = 0;
  logic [1:0]  op_code = 0;
  logic [4:0]  op_src = 0;
  logic [31:0] op_val = 0;
  logic        op_busy, op_done, op_unhandled, op_swcheck, op_fault;
  logic [31:0] op_rdata, op_tval;
  logic [4:0]  op_cause;
  logic        mem_req, mem_we, mem_ready = 0, mem_rvalid = 0, mem_err = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic        csr_we = 0;
  logic [11:0] csr_addr = 12'h011;
  logic [31:0] csr_wdata = 0, csr_rdata;

  sstk_unit dut (.*);

  always #2 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0] eptr = 0;
  logic [31:0] memw [64];

  function automatic logic [31:0] keep(input logic [31:0] v);
    return v & 32'hFFFF_FFFC;
  endfunction
  function automatic int idx(input logic [31:0] a);
    return int'(a[7:2]);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_ptr(input string req);
    chk(csr_rdata == eptr, req, csr_rdata, eptr);
  endtask

  task automatic csr_write(input logic [11:0] a, input logic [31:0] d);
    csr_addr = a; csr_wdata = d; csr_we = 1;
    @(negedge clk);
    csr_we = 0; csr_addr = 12'h011;
    if (a == 12'h011) eptr = keep(d);
  endtask

  task automatic run_op(input logic [1:0] code, input logic [4:0] src, input logic [31:0] val,
                        input bit err, input bit collide, input bit poke, input string req);
    logic [31:0] p0, a, rd;
    bit is_mem, ok_cmp;
    p0 = eptr;
    op_valid = 1; op_code = code; op_src = src; op_val = val;
    @(negedge clk);
    op_valid = 0;
    is_mem = en && code < 2 && (src == 1 || src == 5);
    if (is_mem) begin
      a = (code == 0) ? p0 - 4 : p0;
      chk(mem_req && mem_we == (code == 0) && mem_addr == a, req, mem_addr, a);
      if (code == 0) chk(mem_wdata == val, "R1", mem_wdata, val);
      chk(op_busy == 1, "R11", op_busy, 1);
      repeat ($urandom % 3) begin
        if (poke) begin op_valid = 1; op_code = 2'd2; end
        @(negedge clk);
        chk(!op_done && mem_req, "R11", op_done, 0);
      end
      op_valid = 0;
      mem_ready = 1;
      @(negedge clk);
      mem_ready = 0;
      repeat ($urandom % 3) begin
        if (poke) begin op_valid = 1; op_code = 2'd3; end
        @(negedge clk);
        chk(!op_done && !mem_req, "R11", op_done, 0);
      end
      op_valid = 0;
      rd = memw[idx(a)];
      mem_rdata = rd; mem_err = err; mem_rvalid = 1;
      if (collide) begin csr_we = 1; csr_wdata = 32'h0000_ABC3; end
      @(negedge clk);
      mem_rvalid = 0; mem_err = 0; csr_we = 0;
      ok_cmp = (code == 0) || (rd == val);
      chk(op_done == 1, req, op_done, 1);
      chk(op_fault == err, err ? "R5" : req, op_fault, err);
      chk(op_swcheck == (!err && !ok_cmp), "R4", op_swcheck, !err && !ok_cmp);
      if (!err && !ok_cmp) chk(op_cause == 18 && op_tval == 3, "R4", {op_cause, op_tval}, {5'd18, 32'd3});
      if (!err && ok_cmp) begin
        eptr = (code == 0) ? a : a + 4;
        if (code == 0) memw[idx(a)] = val;
      end else if (collide) eptr = 32'h0000_ABC0;
      chk_ptr(collide ? "R12" : req);
    end else begin
      chk(op_done == 1 && !mem_req, req, op_done, 1);
      chk(op_unhandled == (code == 3 || (en && code < 2)), "R10", op_unhandled, code == 3 || (en && code < 2));
      chk(op_rdata == ((code == 2 && en) ? p0 : 32'h0), code == 2 ? (en ? "R9" : "R8") : req, op_rdata, (code == 2 && en) ? p0 : 0);
      chk(!op_fault && !op_swcheck, req, {op_fault, op_swcheck}, 0);
      chk_ptr(req);
    end
    @(negedge clk);
    chk(op_done == 0, "R11", op_done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    for (int i = 0; i < 64; i++) memw[i] = 32'h0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!op_busy && !op_done && !mem_req && csr_rdata == 0, "R7", csr_rdata, 0);

    csr_write(12'h011, 32'h0000_1003);
    chk(csr_rdata == 32'h1000, "R6", csr_rdata, 32'h1000);
    csr_write(12'h012, 32'h0000_0500);
    csr_addr = 12'h012; #1;
    chk(csr_rdata == 0, "R7", csr_rdata, 0);
    csr_addr = 12'h011; #1;
    chk_ptr("R7");
    csr_write(12'h011, 32'h0000_0200);

    run_op(2'd0, 5'd1, 32'hCAFE_0001, 0, 0, 0, "R1");
    run_op(2'd0, 5'd5, 32'hCAFE_0002, 0, 0, 1, "R1");
    run_op(2'd1, 5'd5, 32'hCAFE_0002, 0, 0, 0, "R3");
    run_op(2'd1, 5'd1, 32'hDEAD_0000, 0, 0, 0, "R4");
    run_op(2'd0, 5'd1, 32'h1234_5678, 1, 0, 0, "R2");
    run_op(2'd1, 5'd1, 32'hDEAD_0001, 1, 0, 0, "R5");
    run_op(2'd2, 5'd0, 32'h0, 0, 0, 0, "R9");
    run_op(2'd0, 5'd2, 32'h1, 0, 0, 0, "R10");
    run_op(2'd3, 5'd1, 32'h1, 0, 0, 0, "R10");
    en = 0;
    run_op(2'd2, 5'd0, 32'h0, 0, 0, 0, "R8");
    run_op(2'd0, 5'd1, 32'h7, 0, 0, 0, "R8");
    run_op(2'd1, 5'd5, 32'h7, 0, 0, 0, "R8");
    en = 1;
    run_op(2'd1, 5'd1, 32'hCAFE_0001, 0, 1, 0, "R12");
    run_op(2'd1, 5'd1, 32'hBAD0_BAD0, 0, 1, 0, "R12");
    csr_write(12'h011, 32'h0000_0100);

    for (int i = 0; i < 400; i++) begin
      logic [1:0] c; logic [4:0] s; logic [31:0] v; int r;
      r = $urandom % 10;
      c = (r < 4) ? 2'd0 : (r < 8) ? 2'd1 : (r < 9) ? 2'd2 : 2'd3;
      r = $urandom % 8;
      s = (r < 3) ? 5'd1 : (r < 6) ? 5'd5 : 5'($urandom);
      v = $urandom;
      if (c == 1 && ($urandom % 10) < 7) v = memw[idx(eptr)];
      en = ($urandom % 10) != 0;
      run_op(c, s, v, ($urandom % 10) == 0, ($urandom % 10) == 0, ($urandom % 5) == 0, c == 0 ? "R1" : "R3");
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule